// File: doc/BRIEF.md
# Variable-Width Byte Stream Channel

This block moves data words of one to eight bytes from a producer module to a consumer module through an internal byte queue. The producer states how many bytes its word has and places the word on a 64-bit bus. A packer stage then feeds those bytes into the queue one per cycle, lowest byte first. The consumer states how many bytes it wants. A gatherer stage takes that many bytes from the queue and returns them right-aligned on a 64-bit bus, with every byte above the requested count set to zero.

The queue holds a stream of bytes, not a list of words, so word boundaries on the two sides do not have to match. An eight-byte write can be read back as a three-byte word followed by a five-byte word. The consumer may also post its request before the producer has written anything. Each side has a ready output that controls the flow. Traffic in both directions needs two instances of the block.

Top module: `byte_lane_channel`

## Requirements
- R1: While and just after the synchronous reset `rst` is high, `wr_ready` = 1, `rd_ready` = 1, `rd_word` = 0, and the byte queue is empty.
- R2: A write is taken on a rising clock edge where `wr_ready` = 1 and `wr_cnt` ≠ 0. Only the low `wr_cnt`×8 bits of `wr_word` enter the queue; higher bits never appear on the read side.
- R3: After a write of N bytes is taken, `wr_ready` is low for exactly the next N cycles, one byte being queued per cycle. It then returns high if there is room.
- R4: `wr_ready` is high only while the packer is idle and at least 8 free byte slots remain in the queue (depth `DEPTH`, default 64). The queue never overflows.
- R5: Bytes leave the channel in the order they entered, and each word is split lowest byte first. A word written with N bytes and read back with N bytes returns its original value, and reads may split or merge written words at any byte boundary.
- R6: A read is taken on a rising edge where `rd_ready` = 1 and `rd_cnt` ≠ 0. `rd_ready` then stays low until N bytes have been collected. When `rd_ready` rises again, `rd_word` holds the result, and it keeps that value until the next read is taken.
- R7: A read posted while the queue holds fewer than N bytes keeps `rd_ready` low for as long as the bytes are missing. It completes once the bytes have been written.
- R8: When a read of N bytes completes, bits 8N and above of `rd_word` are zero.
- R9: Reset cancels a pending read and discards the bytes in the queue. Bytes written after reset are the first bytes read.
- R10: A count value from 9 to 15 on `wr_cnt` or `rd_cnt` is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_ready | output | 1 | Channel can take a write this cycle |
| wr_cnt | input | 4 | Bytes in the word being written (0 = no write) |
| wr_word | input | 64 | Word to write, right-aligned |
| rd_ready | output | 1 | Channel can take a read request; result valid |
| rd_cnt | input | 4 | Bytes requested (0 = no request) |
| rd_word | output | 64 | Read result, right-aligned, upper bytes zero |

## Verification
The hardest situation to reach is a queue that sits just under the room threshold while the writer is stalled, because that needs enough writes with no reader to bring the queue to 57 bytes. The bench does this with seven eight-byte writes and one single-byte write. It then shows that `wr_ready` stays low until a one-byte read restores room. A pending read that is partly filled when reset arrives is also set up on purpose: three bytes are written under an eight-byte request, and reset is applied while the gatherer waits for the rest. The bench also posts a read before any data exists, to check the early-request behaviour.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;

  // Clamp a requested byte count to the widest word the channel carries.
  function automatic int unsigned sat_bytes(input int unsigned raw,
                                            input int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // True when the queue can absorb a full-width word.
  function automatic logic has_room(input int unsigned level,
                                    input int unsigned depth,
                                    input int unsigned need);
    return (depth - level) >= need;
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             pop,
  output logic [7:0]       head,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (level_q == '0);
  assign level = level_q;
endmodule

// File: rtl/byte_packer.sv
module byte_packer
  import byte_lane_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned WORD_W = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              room,
  input  logic [3:0]        wr_cnt,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_ready,
  output logic              accept,
  output logic              push,
  output logic [7:0]        push_byte
);
  logic [CNT_W-1:0]  rem_q;
  logic [WORD_W-1:0] word_q;
  logic              busy;

  assign busy      = (rem_q != '0);
  assign wr_ready  = !busy && room;
  assign accept    = wr_ready && (wr_cnt != 4'd0);
  assign push      = busy;
  assign push_byte = word_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      word_q <= '0;
    end else if (accept) begin
      rem_q  <= CNT_W'(sat_bytes(32'(wr_cnt), MAX_BYTES));
      word_q <= wr_word;
    end else if (busy) begin
      rem_q  <= rem_q - 1'b1;
      word_q <= word_q >> 8;
    end
  end
endmodule

// File: rtl/byte_gatherer.sv
module byte_gatherer
  import byte_lane_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W  = $clog2(MAX_BYTES),
  localparam int unsigned WORD_W = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_cnt,
  input  logic              q_empty,
  input  logic [7:0]        q_head,
  output logic              rd_ready,
  output logic              accept,
  output logic              pop,
  output logic [WORD_W-1:0] rd_word
);
  logic [CNT_W-1:0]  need_q;
  logic [IDX_W-1:0]  pos_q;
  logic [WORD_W-1:0] word_q;
  logic              waiting;

  assign waiting  = (need_q != '0);
  assign rd_ready = !waiting;
  assign accept   = rd_ready && (rd_cnt != 4'd0);
  assign pop      = waiting && !q_empty;
  assign rd_word  = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      need_q <= '0;
      pos_q  <= '0;
      word_q <= '0;
    end else if (accept) begin
      need_q <= CNT_W'(sat_bytes(32'(rd_cnt), MAX_BYTES));
      pos_q  <= '0;
      word_q <= '0;
    end else if (pop) begin
      word_q[{pos_q, 3'b000} +: 8] <= q_head;
      pos_q  <= pos_q + 1'b1;
      need_q <= need_q - 1'b1;
    end
  end
endmodule

// File: rtl/byte_lane_channel.sv
module byte_lane_channel
  import byte_lane_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned WORD_W = MAX_BYTES * 8,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              wr_ready,
  input  logic [3:0]        wr_cnt,
  input  logic [WORD_W-1:0] wr_word,
  output logic              rd_ready,
  input  logic [3:0]        rd_cnt,
  output logic [WORD_W-1:0] rd_word
);
  // Internal events, named for the checker.
  logic             q_push, q_pop, q_empty, q_room;
  logic [7:0]       q_in, q_head;
  logic [LVL_W-1:0] q_level;
  logic             wr_take, rd_take;

  assign q_room = has_room(32'(q_level), DEPTH, MAX_BYTES);

  byte_packer #(.MAX_BYTES(MAX_BYTES)) u_packer (
    .clk(clk), .rst(rst), .room(q_room), .wr_cnt(wr_cnt), .wr_word(wr_word),
    .wr_ready(wr_ready), .accept(wr_take), .push(q_push), .push_byte(q_in)
  );

  byte_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .push_byte(q_in), .pop(q_pop),
    .head(q_head), .empty(q_empty), .level(q_level)
  );

  byte_gatherer #(.MAX_BYTES(MAX_BYTES)) u_gather (
    .clk(clk), .rst(rst), .rd_cnt(rd_cnt), .q_empty(q_empty), .q_head(q_head),
    .rd_ready(rd_ready), .accept(rd_take), .pop(q_pop), .rd_word(rd_word)
  );
endmodule

// File: rtl/byte_lane_channel_checker.sv
module byte_lane_channel_checker #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned WORD_W = MAX_BYTES * 8,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_ready,
  input logic [3:0]        wr_cnt,
  input logic              rd_ready,
  input logic [3:0]        rd_cnt,
  input logic [WORD_W-1:0] rd_word,
  input logic              q_push,
  input logic              q_pop,
  input logic [LVL_W-1:0]  q_level
);
  logic [3:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 4'd1;
    else if (rd_ready && rd_cnt != 4'd0)
      req_q <= (rd_cnt > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : rd_cnt;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_ready && rd_ready && q_level == '0 && rd_word == '0)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (q_push && !q_pop) |-> (q_level < LVL_W'(DEPTH))); // R4
  AST_ROOM_GATE: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (q_level <= LVL_W'(DEPTH - MAX_BYTES))); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && wr_cnt != 4'd0) |=> !wr_ready); // R3
  AST_RD_WAIT: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && rd_cnt != 4'd0) |=> !rd_ready); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> (q_level != '0)); // R7
  AST_POP_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> !rd_ready); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ready) |-> ((rd_word >> {req_q, 3'b000}) == '0)); // R8
endmodule

bind byte_lane_channel byte_lane_channel_checker #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst), .wr_ready(wr_ready), .wr_cnt(wr_cnt),
  .rd_ready(rd_ready), .rd_cnt(rd_cnt), .rd_word(rd_word),
  .q_push(q_push), .q_pop(q_pop), .q_level(q_level)
);

// File: tb/byte_lane_channel_bench.sv
module byte_lane_channel_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_ready, rd_ready;
  logic [3:0]  wr_cnt, rd_cnt;
  logic [63:0] wr_word, rd_word;

  int tests = 0;
  int fails = 0;
  logic [7:0] sb_q[$];

  always #4 clk = ~clk;

  byte_lane_channel u_byte_lane_channel (
    .clk(clk), .rst(rst), .wr_ready(wr_ready), .wr_cnt(wr_cnt), .wr_word(wr_word),
    .rd_ready(rd_ready), .rd_cnt(rd_cnt), .rd_word(rd_word)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Driver: offers a word and records its bytes in the scoreboard.
  task automatic put(input int n, input logic [63:0] w);
    int eff;
    eff = (n > 8) ? 8 : n;
    while (!wr_ready) @(negedge clk);
    wr_cnt  = 4'(n);
    wr_word = w;
    for (int i = 0; i < eff; i++) sb_q.push_back(w[i*8 +: 8]);
    @(negedge clk);
    wr_cnt  = 4'd0;
    wr_word = {8{8'hA5}};
  endtask

  // Posts a request, then acts as monitor: waits for the result and compares.
  task automatic get(input int n, input string req);
    logic [63:0] exp;
    int eff;
    eff = (n > 8) ? 8 : n;
    while (!rd_ready) @(negedge clk);
    rd_cnt = 4'(n);
    @(negedge clk);
    rd_cnt = 4'd0;
    while (!rd_ready) @(negedge clk);
    exp = '0;
    for (int i = 0; i < eff; i++) exp[i*8 +: 8] = sb_q.pop_front();
    check(req, rd_word, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lowc;
    rst = 1'b1; wr_cnt = '0; rd_cnt = '0; wr_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 wr_ready", 64'(wr_ready), 64'd1);
    check("R1 rd_ready", 64'(rd_ready), 64'd1);
    check("R1 rd_word", rd_word, 64'd0);

    // R2 R3: an 8-byte write keeps wr_ready low for 8 cycles; the upper garbage in a 3-byte write is dropped
    while (!wr_ready) @(negedge clk);
    wr_cnt = 4'd8; wr_word = 64'h0807_0605_0403_0201;
    for (int i = 0; i < 8; i++) sb_q.push_back(wr_word[i*8 +: 8]);
    @(negedge clk);
    wr_cnt = 4'd0;
    lowc = 0;
    while (!wr_ready) begin lowc++; @(negedge clk); end
    check("R3 busy cycles", 64'(lowc), 64'd8);
    get(8, "R5 round trip 8");
    put(3, 64'hDEAD_BEEF_00C3_B2A1);
    get(3, "R2 low bytes only");

    // R5: a written word split across reads, and two words merged into one read
    put(8, 64'h1122_3344_5566_7788);
    get(3, "R5 split first");
    get(5, "R5 split second");
    put(2, 64'h0000_0000_0000_BBAA);
    put(2, 64'h0000_0000_0000_DDCC);
    get(4, "R5 merge");
    put(1, 64'hFFFF_FFFF_FFFF_FF5A);
    get(1, "R8 one byte, upper zero");

    // R10: a count above 8 acts as 8
    put(12, 64'h0F1E_2D3C_4B5A_6978);
    get(13, "R10 saturated count");

    // R7: a read posted before any data waits
    rd_cnt = 4'd4;
    @(negedge clk);
    rd_cnt = 4'd0;
    repeat (10) @(negedge clk);
    check("R7 waits on empty", 64'(rd_ready), 64'd0);
    put(4, 64'h0000_0000_CAFE_F00D);
    while (!rd_ready) @(negedge clk);
    check("R7 early read result", rd_word, 64'h0000_0000_CAFE_F00D);
    void'(sb_q.pop_front()); void'(sb_q.pop_front());
    void'(sb_q.pop_front()); void'(sb_q.pop_front());

    // R4: fill to 57 bytes with no reader
    for (int k = 0; k < 7; k++) put(8, {8{8'(k + 16)}} ^ 64'h0001_0203_0405_0607);
    put(1, 64'h0000_0000_0000_0077);
    repeat (12) @(negedge clk);
    check("R4 low when short of room", 64'(wr_ready), 64'd0);
    get(1, "R4 first byte out");
    @(negedge clk);
    check("R4 room restored", 64'(wr_ready), 64'd1);
    for (int k = 0; k < 7; k++) get(8, "R5 drain after fill");

    // R9: reset during a partly filled read
    put(3, 64'h0000_0000_0033_2211);
    rd_cnt = 4'd8;
    @(negedge clk);
    rd_cnt = 4'd0;
    repeat (6) @(negedge clk);
    check("R9 pending before reset", 64'(rd_ready), 64'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sb_q.delete();
    @(negedge clk);
    check("R9 rd_ready after reset", 64'(rd_ready), 64'd1);
    check("R9 rd_word after reset", rd_word, 64'd0);
    check("R1 wr_ready after reset", 64'(wr_ready), 64'd1);
    put(2, 64'h0000_0000_0000_9988);
    get(2, "R9 fresh bytes first");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule